// File: doc/BRIEF.md
# Half-Precision Vector ALU Lane

This block is one lane of a vector arithmetic unit working on 16-bit half-precision values (1 sign bit, 5 exponent bits with bias 15, 10 fraction bits). Each accepted operation carries an opcode, two source operands, the current value of the destination register, a 16-bit literal word and per-operation modifiers. The lane computes one of seven operations: add, subtract, reverse subtract, multiply, multiply-accumulate into the destination, and two multiply-add forms that take the literal either as the multiplier or as the addend.

Source modifiers (absolute value, then negation) act on the two source operands only. An output scale factor is honoured only by the multiply-accumulate form, and an optional clamp saturates the final value into the unit interval. Subnormal values are treated as signed zeros on input and on output. The multiply-add forms round the product to half precision before adding, so they are not fused.

Operations enter through a valid/ready stream and leave through a second one. One result register sits between them. When the consumer stalls, the result holds and the input side stops accepting. When the consumer takes the result, a new operation can enter in the same cycle.

Top module: `hvl_lane`

## Requirements
- R1: Opcode 31 returns SRC0+SRC1, opcode 32 returns SRC0−SRC1, opcode 33 returns SRC1−SRC0. An exact zero difference is +0 (0x0000).
- R2: Opcode 34 returns SRC0×SRC1.
- R3: Opcode 35 returns SRC0×SRC1 + DST, where DST is the `in_dst` value.
- R4: Opcode 36 returns SRC0×LIT + SRC1, where LIT is the `in_lit` value.
- R5: Opcode 37 returns SRC0×SRC1 + LIT.
- R6: For each source (bit 0 of `in_abs`/`in_neg` = SRC0, bit 1 = SRC1), absolute value clears the sign, then negate inverts it; both together give −|x|. DST and LIT are never modified.
- R7: Every rounding is to nearest, ties to even. In opcodes 35–37 the product is rounded to half precision before the addition.
- R8: An input with exponent field 0 is a signed zero. A result below 2^-14 becomes a zero of the result's sign. Any NaN input, ∞−∞ and 0×∞ give 0x7E00. Overflow gives ±∞ (0x7C00/0xFC00).
- R9: `in_omod` (0 none, 1 ×2, 2 ×4, 3 ÷2) scales the result of opcode 35 only. It is applied before clamping and has no effect on other opcodes.
- R10: With `in_clamp` set, a NaN or negative result (including −0) becomes 0x0000, and a result above 1.0 becomes 0x3C00.
- R11: Any opcode outside 31..37 returns 0x0000.
- R12: An operation accepted on a clock edge (`in_valid` && `in_ready`) appears on `out_res` with `out_valid` high after that edge. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` && !`out_ready`, the output holds stable and input is not taken. After reset `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Lane can take an operation this cycle |
| in_op | input | 6 | Opcode |
| in_src0 | input | 16 | First source operand |
| in_src1 | input | 16 | Second source operand |
| in_dst | input | 16 | Current destination value |
| in_lit | input | 16 | Literal constant word |
| in_neg | input | 2 | Negate flags, bit 0 SRC0, bit 1 SRC1 |
| in_abs | input | 2 | Absolute-value flags, bit 0 SRC0, bit 1 SRC1 |
| in_clamp | input | 1 | Clamp result into [0.0, 1.0] |
| in_omod | input | 2 | Output scale code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 16 | Half-precision result |

## Verification
The bench targets the two literal forms with operands chosen so that swapping the literal's role gives a different value (9.0 against 6.0). It also targets a product whose exact value is a rounding tie, where a fused implementation returns 0x1600 instead of 0x1800. Tie-to-even cases on addition would show up as an off-by-one fraction from a design that rounds half up. The output scale is tried on a non-accumulate opcode, where a leaky design would double the result. It is also combined with the clamp, where the wrong order yields 2.0 instead of 1.0. Stalls are exercised with a second operation waiting, so a lane that overwrote its held result or dropped the queued operation would show a wrong value.

// File: rtl/hvl_pkg.sv
package hvl_pkg;
  localparam int FP_W   = 16;
  localparam int EXP_W  = 5;
  localparam int FRAC_W = FP_W - EXP_W - 1;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EXT_W  = EXP_W + 3;
  localparam int OP_W   = 6;

  localparam logic [EXP_W-1:0]  EXP_ONES  = {EXP_W{1'b1}};
  localparam logic [FRAC_W-1:0] FRAC_ZERO = '0;
  localparam logic [FP_W-1:0]   QNAN      = {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [FP_W-1:0]   FP_ONE    = {1'b0, 1'b0, {(EXP_W-1){1'b1}}, FRAC_ZERO};

  localparam logic signed [EXT_W-1:0] X_ZERO = '0;
  localparam logic signed [EXT_W-1:0] X_ONE  = EXT_W'(1);
  localparam logic signed [EXT_W-1:0] X_TWO  = EXT_W'(2);
  localparam logic signed [EXT_W-1:0] X_BIAS = EXT_W'(BIAS);
  localparam logic signed [EXT_W-1:0] X_EMAX = EXT_W'((1 << EXP_W) - 1);

  localparam logic [OP_W-1:0] OPC_ADD    = 6'd31;
  localparam logic [OP_W-1:0] OPC_SUB    = 6'd32;
  localparam logic [OP_W-1:0] OPC_SUBREV = 6'd33;
  localparam logic [OP_W-1:0] OPC_MUL    = 6'd34;
  localparam logic [OP_W-1:0] OPC_MAC    = 6'd35;
  localparam logic [OP_W-1:0] OPC_MADMK  = 6'd36;
  localparam logic [OP_W-1:0] OPC_MADAK  = 6'd37;

  typedef enum logic [1:0] {OM_NONE = 2'd0, OM_X2 = 2'd1, OM_X4 = 2'd2, OM_HALF = 2'd3} omod_e;

  function automatic logic op_known(logic [OP_W-1:0] op);
    return (op >= OPC_ADD) && (op <= OPC_MADAK);
  endfunction

  function automatic logic signed [EXT_W-1:0] xe(logic [EXP_W-1:0] e);
    return signed'({{(EXT_W-EXP_W){1'b0}}, e});
  endfunction

  // Round a normalised significand to nearest-even and pack it; handles
  // carry-out of rounding, overflow to infinity and flush of tiny results.
  function automatic logic [FP_W-1:0] pack_rne(logic s, logic signed [EXT_W-1:0] e,
                                               logic [SIG_W-1:0] sig, logic g, logic st);
    logic [SIG_W:0] r;
    logic signed [EXT_W-1:0] ef;
    r  = {1'b0, sig} + {{SIG_W{1'b0}}, g & (st | sig[0])};
    ef = e;
    if (r[SIG_W]) begin
      ef = e + X_ONE;
      r  = r >> 1;
    end
    if (ef >= X_EMAX) return {s, EXP_ONES, FRAC_ZERO};
    if (ef <= X_ZERO) return {s, {(FP_W-1){1'b0}}};
    return {s, ef[EXP_W-1:0], r[FRAC_W-1:0]};
  endfunction
endpackage

// File: rtl/hvl_opnd.sv
module hvl_opnd
  import hvl_pkg::*;
(
  input  logic [FP_W-1:0] raw,
  input  logic            neg,
  input  logic            abs_en,
  output logic [FP_W-1:0] y
);
  always_comb begin
    y = raw;
    if (abs_en) y[FP_W-1] = 1'b0;
    if (neg)    y[FP_W-1] = ~y[FP_W-1];
    // subnormal or zero: keep only the sign
    if (y[FP_W-2 -: EXP_W] == '0) y[FP_W-2:0] = '0;
  end
endmodule

// File: rtl/hvl_fmul.sv
module hvl_fmul
  import hvl_pkg::*;
(
  input  logic [FP_W-1:0] a,
  input  logic [FP_W-1:0] b,
  output logic [FP_W-1:0] y
);
  localparam int PROD_W = 2 * SIG_W;

  logic              sa, sb, s;
  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  logic              a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;
  logic [PROD_W-1:0] prod;
  logic [SIG_W-1:0]  sig;
  logic              g, st;
  logic signed [EXT_W-1:0] e;

  always_comb begin
    {sa, ea, fa} = a;
    {sb, eb, fb} = b;
    s      = sa ^ sb;
    a_nan  = (ea == EXP_ONES) && (fa != '0);
    b_nan  = (eb == EXP_ONES) && (fb != '0);
    a_inf  = (ea == EXP_ONES) && (fa == '0);
    b_inf  = (eb == EXP_ONES) && (fb == '0);
    a_zero = (ea == '0);
    b_zero = (eb == '0);
    prod   = {{SIG_W{1'b0}}, 1'b1, fa} * {{SIG_W{1'b0}}, 1'b1, fb};
    e      = xe(ea) + xe(eb) - X_BIAS;
    if (prod[PROD_W-1]) begin
      sig = prod[PROD_W-1 -: SIG_W];
      g   = prod[PROD_W-1-SIG_W];
      st  = |prod[PROD_W-2-SIG_W:0];
      e   = e + X_ONE;
    end else begin
      sig = prod[PROD_W-2 -: SIG_W];
      g   = prod[PROD_W-2-SIG_W];
      st  = |prod[PROD_W-3-SIG_W:0];
    end
    if (a_nan || b_nan || (a_inf && b_zero) || (b_inf && a_zero)) y = QNAN;
    else if (a_inf || b_inf)   y = {s, EXP_ONES, FRAC_ZERO};
    else if (a_zero || b_zero) y = {s, {(FP_W-1){1'b0}}};
    else                       y = pack_rne(s, e, sig, g, st);
  end
endmodule

// File: rtl/hvl_fadd.sv
module hvl_fadd
  import hvl_pkg::*;
(
  input  logic [FP_W-1:0] a,
  input  logic [FP_W-1:0] b,
  output logic [FP_W-1:0] y
);
  localparam int WORK_W = SIG_W + 3;
  localparam int ALN_W  = 2 * SIG_W + 2;
  localparam logic [EXP_W-1:0] ALN_LIM = EXP_W'(ALN_W);

  logic              sa, sb, sl, ss;
  logic [EXP_W-1:0]  ea, eb, el, es, dsh, lz;
  logic [FRAC_W-1:0] fa, fb, fl, fs;
  logic              a_nan, b_nan, a_inf, b_inf, a_zero, b_zero, found;
  logic [ALN_W-1:0]  aln;
  logic [WORK_W-1:0] maw, mbw, dif, nrm;
  logic [WORK_W:0]   sum;
  logic signed [EXT_W-1:0] ex;

  always_comb begin
    {sa, ea, fa} = a;
    {sb, eb, fb} = b;
    a_nan  = (ea == EXP_ONES) && (fa != '0);
    b_nan  = (eb == EXP_ONES) && (fb != '0);
    a_inf  = (ea == EXP_ONES) && (fa == '0);
    b_inf  = (eb == EXP_ONES) && (fb == '0);
    a_zero = (ea == '0);
    b_zero = (eb == '0);
    if (a[FP_W-2:0] >= b[FP_W-2:0]) begin
      {sl, el, fl} = a; {ss, es, fs} = b;
    end else begin
      {sl, el, fl} = b; {ss, es, fs} = a;
    end
    dsh = el - es;
    aln = {1'b1, fs, {(ALN_W-SIG_W){1'b0}}} >> dsh;
    maw = {1'b1, fl, {(WORK_W-SIG_W){1'b0}}};
    mbw = {aln[ALN_W-1 -: WORK_W-1],
           aln[ALN_W-WORK_W] | (|aln[ALN_W-WORK_W-1:0]) | (dsh >= ALN_LIM)};
    sum   = '0;
    dif   = '0;
    lz    = '0;
    found = 1'b0;
    if (sl == ss) begin
      sum = {1'b0, maw} + {1'b0, mbw};
      if (sum[WORK_W]) begin
        nrm = {sum[WORK_W:2], sum[1] | sum[0]};
        ex  = xe(el) + X_ONE;
      end else begin
        nrm = sum[WORK_W-1:0];
        ex  = xe(el);
      end
    end else begin
      dif = maw - mbw;
      for (int i = 0; i < WORK_W; i++) begin
        if (!found && dif[WORK_W-1-i]) begin
          lz    = EXP_W'(i);
          found = 1'b1;
        end
      end
      nrm = dif << lz;
      ex  = xe(el) - xe(lz);
    end
    if (a_nan || b_nan || (a_inf && b_inf && (sa != sb))) y = QNAN;
    else if (a_inf)              y = a;
    else if (b_inf)              y = b;
    else if (a_zero && b_zero)   y = {sa & sb, {(FP_W-1){1'b0}}};
    else if (a_zero)             y = b;
    else if (b_zero)             y = a;
    else if (sl != ss && dif == '0) y = '0;
    else y = pack_rne(sl, ex, nrm[WORK_W-1 -: SIG_W], nrm[WORK_W-1-SIG_W],
                      |nrm[WORK_W-2-SIG_W:0]);
  end
endmodule

// File: rtl/hvl_post.sv
module hvl_post
  import hvl_pkg::*;
(
  input  logic [FP_W-1:0] r,
  input  logic            scale_en,
  input  logic [1:0]      omod,
  input  logic            clamp_en,
  output logic [FP_W-1:0] y
);
  logic              s;
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;
  logic [FP_W-1:0]   t;
  logic signed [EXT_W-1:0] adj;

  always_comb begin
    {s, e, f} = r;
    t = r;
    unique case (omod_e'(omod))
      OM_X2:   adj = X_ONE;
      OM_X4:   adj = X_TWO;
      OM_HALF: adj = -X_ONE;
      default: adj = X_ZERO;
    endcase
    // scaling only touches finite non-zero values of the accumulate form
    if (scale_en && adj != X_ZERO && e != '0 && e != EXP_ONES)
      t = pack_rne(s, xe(e) + adj, {1'b1, f}, 1'b0, 1'b0);
    y = t;
    if (clamp_en) begin
      if (t[FP_W-2 -: EXP_W] == EXP_ONES && t[FRAC_W-1:0] != '0) y = '0;
      else if (t[FP_W-1])                        y = '0;
      else if (t[FP_W-2:0] > FP_ONE[FP_W-2:0])   y = FP_ONE;
    end
  end
endmodule

// File: rtl/hvl_lane.sv
module hvl_lane
  import hvl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [FP_W-1:0]   in_src0,
  input  logic [FP_W-1:0]   in_src1,
  input  logic [FP_W-1:0]   in_dst,
  input  logic [FP_W-1:0]   in_lit,
  input  logic [1:0]        in_neg,
  input  logic [1:0]        in_abs,
  input  logic              in_clamp,
  input  logic [1:0]        in_omod,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FP_W-1:0]   out_res
);
  localparam int N_SRC  = 2;
  localparam int N_OPND = N_SRC + 2;
  localparam int I_S0 = 0, I_S1 = 1, I_DST = 2, I_LIT = 3;

  logic [FP_W-1:0]   raw [N_OPND];
  logic [FP_W-1:0]   opv [N_OPND];
  logic [N_OPND-1:0] negv, absv;
  logic [FP_W-1:0]   mul_b, prod, add_x, add_y, sum, pre, post_r, res;

  always_comb begin
    raw[I_S0]  = in_src0;
    raw[I_S1]  = in_src1;
    raw[I_DST] = in_dst;
    raw[I_LIT] = in_lit;
  end
  assign negv = {{(N_OPND-N_SRC){1'b0}}, in_neg};
  assign absv = {{(N_OPND-N_SRC){1'b0}}, in_abs};

  genvar gi;
  generate
    for (gi = 0; gi < N_OPND; gi++) begin : g_opnd
      hvl_opnd u_opnd (.raw(raw[gi]), .neg(negv[gi]), .abs_en(absv[gi]), .y(opv[gi]));
    end
  endgenerate

  assign mul_b = (in_op == OPC_MADMK) ? opv[I_LIT] : opv[I_S1];
  hvl_fmul u_fmul (.a(opv[I_S0]), .b(mul_b), .y(prod));

  always_comb begin
    add_x = opv[I_S0];
    add_y = opv[I_S1];
    case (in_op)
      OPC_SUB:    add_y = {~opv[I_S1][FP_W-1], opv[I_S1][FP_W-2:0]};
      OPC_SUBREV: begin
        add_x = opv[I_S1];
        add_y = {~opv[I_S0][FP_W-1], opv[I_S0][FP_W-2:0]};
      end
      OPC_MAC:    begin add_x = prod; add_y = opv[I_DST]; end
      OPC_MADMK:  begin add_x = prod; add_y = opv[I_S1];  end
      OPC_MADAK:  begin add_x = prod; add_y = opv[I_LIT]; end
      default: ;
    endcase
  end
  hvl_fadd u_fadd (.a(add_x), .b(add_y), .y(sum));

  assign pre = (in_op == OPC_MUL) ? prod : sum;
  hvl_post u_post (.r(pre), .scale_en(in_op == OPC_MAC), .omod(in_omod),
                   .clamp_en(in_clamp), .y(post_r));
  assign res = op_known(in_op) ? post_r : '0;

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_res   <= res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res));
  a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  a_r10_clamp_range: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_clamp |=> !out_res[FP_W-1] && out_res <= FP_ONE);
  a_r11_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !op_known(in_op) |=> out_res == '0);
  a_r8_canon_nan: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_res[FP_W-2 -: EXP_W] == EXP_ONES && out_res[FRAC_W-1:0] != '0
    |-> out_res == QNAN);
endmodule

// File: tb/test_hvl_lane.sv
module test_hvl_lane;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_clamp = 1'b0, out_valid, out_ready = 1'b1;
  logic [5:0]  in_op = '0;
  logic [15:0] in_src0 = '0, in_src1 = '0, in_dst = '0, in_lit = '0, out_res;
  logic [1:0]  in_neg = '0, in_abs = '0, in_omod = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hvl_lane i_hvl_lane (.*);

  task automatic check(input bit ok, input string tag, input logic [15:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [5:0] op, input logic [15:0] s0, s1, d, l,
                     input logic [1:0] ng, ab, input logic cl, input logic [1:0] om,
                     input logic [15:0] exp, input string tag);
    @(negedge clk);
    in_op = op; in_src0 = s0; in_src1 = s1; in_dst = d; in_lit = l;
    in_neg = ng; in_abs = ab; in_clamp = cl; in_omod = om; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_res === exp, tag, out_res, exp);
  endtask

  task automatic t_reset;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R12 reset", {15'd0, out_valid}, 16'h0);
  endtask

  task automatic t_arith;
    run(31, 16'h3C00, 16'h4000, 0, 0, 0, 0, 0, 0, 16'h4200, "R1 add 1+2");
    run(32, 16'h3C00, 16'h4000, 0, 0, 0, 0, 0, 0, 16'hBC00, "R1 sub 1-2");
    run(33, 16'h3C00, 16'h4000, 0, 0, 0, 0, 0, 0, 16'h3C00, "R1 subrev 2-1");
    run(32, 16'h4000, 16'h4000, 0, 0, 0, 0, 0, 0, 16'h0000, "R1 sub exact zero");
  endtask

  task automatic t_mul;
    run(34, 16'h3E00, 16'h4000, 0, 0, 0, 0, 0, 0, 16'h4200, "R2 mul 1.5*2");
    run(34, 16'h4200, 16'hC000, 0, 0, 0, 0, 0, 0, 16'hC600, "R2 mul 3*-2");
  endtask

  task automatic t_mac;
    run(35, 16'h4000, 16'h4200, 16'h3C00, 0, 0, 0, 0, 0, 16'h4700, "R3 mac 2*3+1");
  endtask

  task automatic t_lits;
    run(36, 16'h4000, 16'h3C00, 0, 16'h4400, 0, 0, 0, 0, 16'h4880, "R4 madmk 2*4+1");
    run(37, 16'h4000, 16'h3C00, 0, 16'h4400, 0, 0, 0, 0, 16'h4600, "R5 madak 2*1+4");
  endtask

  task automatic t_mods;
    run(31, 16'h3C00, 16'hC000, 0, 0, 2'b01, 2'b11, 0, 0, 16'h3C00, "R6 -|1| + |-2|");
    run(35, 16'h4000, 16'h4200, 16'h3C00, 0, 2'b01, 0, 0, 0, 16'hC500, "R6 mac neg src0, dst untouched");
    run(37, 16'h4000, 16'h3C00, 0, 16'h4400, 2'b10, 0, 0, 0, 16'h4000, "R6 madak neg src1, lit untouched");
  endtask

  task automatic t_round;
    run(31, 16'h3C00, 16'h1000, 0, 0, 0, 0, 0, 0, 16'h3C00, "R7 tie to even down");
    run(31, 16'h3C01, 16'h1000, 0, 0, 0, 0, 0, 0, 16'h3C02, "R7 tie to even up");
    run(37, 16'h3C01, 16'h3E00, 0, 16'hBE00, 0, 0, 0, 0, 16'h1800, "R7 product rounded before add");
  endtask

  task automatic t_special;
    run(31, 16'h7C01, 16'h3C00, 0, 0, 0, 0, 0, 0, 16'h7E00, "R8 nan input");
    run(31, 16'h7C00, 16'hFC00, 0, 0, 0, 0, 0, 0, 16'h7E00, "R8 inf-inf");
    run(34, 16'h0000, 16'h7C00, 0, 0, 0, 0, 0, 0, 16'h7E00, "R8 zero*inf");
    run(34, 16'h7BFF, 16'h4000, 0, 0, 0, 0, 0, 0, 16'h7C00, "R8 overflow +inf");
    run(34, 16'hC000, 16'h7BFF, 0, 0, 0, 0, 0, 0, 16'hFC00, "R8 overflow -inf");
    run(31, 16'h0200, 16'h3C00, 0, 0, 0, 0, 0, 0, 16'h3C00, "R8 subnormal in flushed");
    run(34, 16'h8001, 16'h3C00, 0, 0, 0, 0, 0, 0, 16'h8000, "R8 signed zero from subnormal");
    run(34, 16'h0400, 16'h3800, 0, 0, 0, 0, 0, 0, 16'h0000, "R8 tiny result flushed");
  endtask

  task automatic t_omod;
    run(35, 16'h4000, 16'h4200, 16'h3C00, 0, 0, 0, 0, 2'd1, 16'h4B00, "R9 mac x2");
    run(35, 16'h4000, 16'h4200, 16'h3C00, 0, 0, 0, 0, 2'd2, 16'h4F00, "R9 mac x4");
    run(35, 16'h4000, 16'h4200, 16'h3C00, 0, 0, 0, 0, 2'd3, 16'h4300, "R9 mac half");
    run(31, 16'h3C00, 16'h4000, 0, 0, 0, 0, 0, 2'd1, 16'h4200, "R9 ignored on add");
    run(34, 16'h3E00, 16'h4000, 0, 0, 0, 0, 0, 2'd2, 16'h4200, "R9 ignored on mul");
    run(35, 16'h3400, 16'h3C00, 16'h3400, 0, 0, 0, 1, 2'd2, 16'h3C00, "R9 scale before clamp");
  endtask

  task automatic t_clamp;
    run(31, 16'h3C00, 16'h4000, 0, 0, 0, 0, 1, 0, 16'h3C00, "R10 clamp high");
    run(32, 16'h3C00, 16'h4000, 0, 0, 0, 0, 1, 0, 16'h0000, "R10 clamp negative");
    run(31, 16'h7C01, 16'h0000, 0, 0, 0, 0, 1, 0, 16'h0000, "R10 clamp nan");
    run(34, 16'h3C00, 16'h3800, 0, 0, 0, 0, 1, 0, 16'h3800, "R10 in range kept");
  endtask

  task automatic t_undef;
    run(0,  16'h3C00, 16'h4000, 0, 0, 0, 0, 0, 0, 16'h0000, "R11 opcode 0");
    run(30, 16'h3C00, 16'h4000, 0, 0, 0, 0, 0, 0, 16'h0000, "R11 opcode 30");
    run(38, 16'h3C00, 16'h4000, 0, 0, 0, 0, 0, 0, 16'h0000, "R11 opcode 38");
  endtask

  task automatic t_flow;
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 31; in_src0 = 16'h3C00; in_src1 = 16'h4000; in_neg = 0; in_abs = 0;
    in_clamp = 0; in_omod = 0; in_valid = 1'b1;
    @(negedge clk);
    in_op = 32;
    check(out_valid === 1'b1 && in_ready === 1'b0 && out_res === 16'h4200,
          "R12 stall raises backpressure", out_res, 16'h4200);
    @(negedge clk);
    check(out_res === 16'h4200 && out_valid === 1'b1, "R12 held while stalled", out_res, 16'h4200);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_res === 16'hBC00, "R12 queued op taken on release", out_res, 16'hBC00);
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R12 drains", {15'd0, out_valid}, 16'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_arith();
    t_mul();
    t_mac();
    t_lits();
    t_mods();
    t_round();
    t_special();
    t_omod();
    t_clamp();
    t_undef();
    t_flow();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule